// File: doc/BRIEF.md
# Hardware-Only Key Slot Store

This block keeps secret keys for three cipher engines (an AES core, a KMAC core and a big-number engine) in slots that software has no path to read. Each slot drives a valid flag and a key bus straight to its engine. The derivation controller fills a slot by raising a load request. The request carries two destination codes: the write-enable destination, which picks the slot that gets written, and the command destination, which was latched from the original software command and selects real key data or random fill. The two codes are decoded apart from each other. When they differ, the block raises a one-cycle fault.

Slots are scrubbed by a level-sensitive clear select. For as long as it names a slot, that slot is rewritten with entropy on every cycle and its valid flag stays low. The engine's life-cycle state also controls the slots. In the disabled state, slot contents and validity are kept and no new load is taken. In the invalid state, every slot is scrubbed and invalidated.

Top module: `keyslot_hub`

## Requirements
- R1: After reset, all three valid outputs are 0, all key buses are 0 and the fault output is 0.
- R2: The destination code is 1 for AES, 2 for KMAC and 3 for the big-number slot. A load whose two destination codes are equal and nonzero writes the low 256 bits of the load key into that AES or KMAC slot, and the slot's valid output is 1 from the next clock edge.
- R3: A matching load to code 3 writes all 384 bits of the load key into the big-number slot and sets its valid output.
- R4: The random fill is the 32-bit random word repeated across the slot width, with word j (bits 32j+31 down to 32j) rotated left by j. A clear-select value of 1, 2 or 3 scrubs only the slot with that code. On every edge while the select holds, that slot takes the fill of the current random word and its valid output is 0.
- R5: Any clear-select value from 4 to 7 scrubs all three slots in the same way.
- R6: A clear-select value of 0 scrubs nothing. When a slot is being scrubbed, a load to that slot on the same edge is ignored.
- R7: While the engine-disabled input is 1, every slot keeps its key and valid flag, and loads are ignored.
- R8: While the engine-invalid input is 1, all slots are scrubbed and invalidated on every edge, and loads are ignored.
- R9: A load request whose two destination codes differ sets the fault output for exactly the next cycle. The slot named by the write-enable code takes random fill and is invalidated. The slot named by the command code is left unchanged.
- R10: Once a slot's valid output has fallen, it stays 0 after the clear select returns to 0. It rises again only through a later matching load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_req_i | input | 1 | Load request from the derivation controller |
| ld_dest_i | input | 2 | Write-enable destination code |
| ld_cmd_dest_i | input | 2 | Destination code of the original command |
| ld_key_i | input | 384 | Key value to load |
| clr_sel_i | input | 3 | Level clear select |
| rnd_i | input | 32 | Random word used for fill |
| eng_disabled_i | input | 1 | Owning engine is in the disabled state |
| eng_invalid_i | input | 1 | Owning engine is in the invalid state |
| aes_vld_o | output | 1 | AES slot valid |
| aes_key_o | output | 256 | AES slot key |
| kmac_vld_o | output | 1 | KMAC slot valid |
| kmac_key_o | output | 256 | KMAC slot key |
| bn_vld_o | output | 1 | Big-number slot valid |
| bn_key_o | output | 384 | Big-number slot key |
| dest_fault_o | output | 1 | Destination mismatch fault, one cycle |

## Verification
Every slot register drives a port directly, so a wrong key or valid state shows on that slot's output one edge after the stimulus that caused it. A decoder that picks the wrong slot, or sends random data where real data belongs, shows as a valid flag set on the wrong engine or a key word that does not match the expected fill or load pattern. Scrub errors show up within one cycle, because the fill follows the random word on every edge. A slot that fails to keep rewriting therefore leaves a key that differs from the current word's fill.

// File: rtl/keyslot_pkg.sv
package keyslot_pkg;
   localparam int unsigned NUM_SLOTS = 3;
   localparam int unsigned DEST_W    = 2;
   localparam int unsigned CLR_W     = 3;

   typedef enum logic [DEST_W-1:0] {
      DEST_NONE = 2'd0,
      DEST_AES  = 2'd1,
      DEST_KMAC = 2'd2,
      DEST_BN   = 2'd3
   } dest_e;

   // slot index of the wide (big-number) slot
   localparam int unsigned WIDE_IDX = 2;
endpackage

// File: rtl/keyslot_fill.sv
module keyslot_fill #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned OUT_W  = 384
) (
   input  logic [WORD_W-1:0] rnd_i,
   output logic [OUT_W-1:0]  fill_o
);
   localparam int unsigned NWORDS = OUT_W / WORD_W;

   for (genvar j = 0; j < NWORDS; j++) begin : g_word
      localparam int unsigned ROT = j % WORD_W;
      if (ROT == 0) begin : g_plain
         assign fill_o[j*WORD_W +: WORD_W] = rnd_i;
      end else begin : g_rot
         assign fill_o[j*WORD_W +: WORD_W] = {rnd_i[WORD_W-1-ROT:0], rnd_i[WORD_W-1:WORD_W-ROT]};
      end
   end
endmodule

// File: rtl/keyslot_dec.sv
module keyslot_dec
   import keyslot_pkg::*;
#(
   parameter int unsigned N = NUM_SLOTS
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ld_req_i,
   input  logic [DEST_W-1:0] ld_dest_i,
   input  logic [DEST_W-1:0] ld_cmd_dest_i,
   input  logic [CLR_W-1:0]  clr_sel_i,
   output logic [N-1:0]      we_o,
   output logic [N-1:0]      dsel_o,
   output logic [N-1:0]      clr_o,
   output logic              fault_o
);
   localparam logic [CLR_W-1:0] CLR_ALL_MIN = CLR_W'(N + 1);

   logic clr_all;
   assign clr_all = (clr_sel_i >= CLR_ALL_MIN);

   for (genvar i = 0; i < N; i++) begin : g_dec
      localparam logic [DEST_W-1:0] CODE = DEST_W'(i + 1);
      // write enable and data select come from independent codes
      assign we_o[i]   = ld_req_i && (ld_dest_i == CODE);
      assign dsel_o[i] = ld_req_i && (ld_cmd_dest_i == CODE);
      assign clr_o[i]  = clr_all || (clr_sel_i == CLR_W'(i + 1));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fault_o <= 1'b0;
      else         fault_o <= ld_req_i && (ld_dest_i != ld_cmd_dest_i);
   end

   assert_mismatch_fault_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_req_i && (ld_dest_i != ld_cmd_dest_i)) |=> fault_o);
   assert_fault_one_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ld_req_i && (ld_dest_i != ld_cmd_dest_i)) |=> !fault_o);
   assert_clear_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_sel_i != '0 && clr_sel_i < CLR_ALL_MIN) |-> $onehot0(clr_o) && clr_o != '0);
endmodule

// File: rtl/keyslot_slot.sv
module keyslot_slot #(
   parameter int unsigned KEY_W = 256
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  logic             dsel_i,
   input  logic             clr_i,
   input  logic             dis_i,
   input  logic             inv_i,
   input  logic [KEY_W-1:0] ld_key_i,
   input  logic [KEY_W-1:0] fill_i,
   output logic             vld_o,
   output logic [KEY_W-1:0] key_o
);
   logic scrub;
   assign scrub = clr_i || inv_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         key_o <= '0;
         vld_o <= 1'b0;
      end else if (scrub) begin
         key_o <= fill_i;
         vld_o <= 1'b0;
      end else if (we_i && !dis_i) begin
         key_o <= dsel_i ? ld_key_i : fill_i;
         vld_o <= dsel_i;
      end
   end

   assert_load_stores_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && dsel_i && !scrub && !dis_i) |=> (vld_o && key_o == $past(ld_key_i)));
   assert_scrub_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      scrub |=> (!vld_o && key_o == $past(fill_i)));
   assert_disabled_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dis_i && !scrub) |=> ($stable(vld_o) && $stable(key_o)));
   assert_rise_needs_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(vld_o) |-> $past(we_i && dsel_i));
endmodule

// File: rtl/keyslot_hub.sv
module keyslot_hub
   import keyslot_pkg::*;
#(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned NARROW_W = 256,
   parameter int unsigned WIDE_W   = 384
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                ld_req_i,
   input  logic [DEST_W-1:0]   ld_dest_i,
   input  logic [DEST_W-1:0]   ld_cmd_dest_i,
   input  logic [WIDE_W-1:0]   ld_key_i,
   input  logic [CLR_W-1:0]    clr_sel_i,
   input  logic [WORD_W-1:0]   rnd_i,
   input  logic                eng_disabled_i,
   input  logic                eng_invalid_i,
   output logic                aes_vld_o,
   output logic [NARROW_W-1:0] aes_key_o,
   output logic                kmac_vld_o,
   output logic [NARROW_W-1:0] kmac_key_o,
   output logic                bn_vld_o,
   output logic [WIDE_W-1:0]   bn_key_o,
   output logic                dest_fault_o
);
   if (NARROW_W % WORD_W != 0 || WIDE_W % WORD_W != 0 || WIDE_W < NARROW_W) begin : g_bad_cfg
      $error("keyslot_hub: slot widths must be word multiples and WIDE_W >= NARROW_W");
   end

   logic [NUM_SLOTS-1:0] we, dsel, clr, vld;
   logic [WIDE_W-1:0]    fill;
   logic [WIDE_W-1:0]    slot_key [NUM_SLOTS];

   keyslot_fill #(.WORD_W(WORD_W), .OUT_W(WIDE_W)) u_fill (
      .rnd_i  (rnd_i),
      .fill_o (fill)
   );

   keyslot_dec #(.N(NUM_SLOTS)) u_dec (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .ld_req_i      (ld_req_i),
      .ld_dest_i     (ld_dest_i),
      .ld_cmd_dest_i (ld_cmd_dest_i),
      .clr_sel_i     (clr_sel_i),
      .we_o          (we),
      .dsel_o        (dsel),
      .clr_o         (clr),
      .fault_o       (dest_fault_o)
   );

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      localparam int unsigned SW = (i == WIDE_IDX) ? WIDE_W : NARROW_W;
      logic [SW-1:0] k;
      keyslot_slot #(.KEY_W(SW)) u_slot (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .we_i     (we[i]),
         .dsel_i   (dsel[i]),
         .clr_i    (clr[i]),
         .dis_i    (eng_disabled_i),
         .inv_i    (eng_invalid_i),
         .ld_key_i (ld_key_i[SW-1:0]),
         .fill_i   (fill[SW-1:0]),
         .vld_o    (vld[i]),
         .key_o    (k)
      );
      assign slot_key[i] = WIDE_W'(k);
   end

   assign aes_vld_o  = vld[0];
   assign kmac_vld_o = vld[1];
   assign bn_vld_o   = vld[WIDE_IDX];
   assign aes_key_o  = slot_key[0][NARROW_W-1:0];
   assign kmac_key_o = slot_key[1][NARROW_W-1:0];
   assign bn_key_o   = slot_key[WIDE_IDX];

   assert_invalid_drops_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eng_invalid_i |=> (!aes_vld_o && !kmac_vld_o && !bn_vld_o));
   assert_clear_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_sel_i > 3'd3) |=> (!aes_vld_o && !kmac_vld_o && !bn_vld_o));
   assert_idle_sel_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_sel_i == '0 && !eng_invalid_i && !ld_req_i) |=> $stable({aes_vld_o, kmac_vld_o, bn_vld_o}));
endmodule

// File: tb/keyslot_hub_tb.sv
`timescale 1ns/1ps
module keyslot_hub_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ld_req = 1'b0;
   logic [1:0]   ld_dest = '0, ld_cmd = '0;
   logic [383:0] ld_key = '0;
   logic [2:0]   clr_sel = '0;
   logic [31:0]  rnd = '0;
   logic         dis = 1'b0, inv = 1'b0;
   logic         aes_vld, kmac_vld, bn_vld, fault;
   logic [255:0] aes_key, kmac_key;
   logic [383:0] bn_key;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   keyslot_hub u_dut (
      .clk_i(clk), .rst_ni(rst_n), .ld_req_i(ld_req), .ld_dest_i(ld_dest),
      .ld_cmd_dest_i(ld_cmd), .ld_key_i(ld_key), .clr_sel_i(clr_sel), .rnd_i(rnd),
      .eng_disabled_i(dis), .eng_invalid_i(inv),
      .aes_vld_o(aes_vld), .aes_key_o(aes_key), .kmac_vld_o(kmac_vld), .kmac_key_o(kmac_key),
      .bn_vld_o(bn_vld), .bn_key_o(bn_key), .dest_fault_o(fault)
   );

   // fields: req, dest, cmd, sel, dis, inv, seed, rnd, exp vld {bn,kmac,aes}, exp fault
   localparam int NV = 17;
   localparam logic [77:0] VEC [NV] = '{
      {1'b1,2'd1,2'd1,3'd0,1'b0,1'b0,32'hA5A50001,32'h11111111,3'b001,1'b0}, // R2 AES load
      {1'b1,2'd2,2'd2,3'd0,1'b0,1'b0,32'h5A5A0002,32'h22222222,3'b011,1'b0}, // R2 KMAC load
      {1'b1,2'd3,2'd3,3'd0,1'b0,1'b0,32'hC3C30003,32'h33333333,3'b111,1'b0}, // R3 wide load
      {1'b0,2'd0,2'd0,3'd1,1'b0,1'b0,32'h0,       32'h8000_0001,3'b110,1'b0}, // R4 clear AES
      {1'b0,2'd0,2'd0,3'd1,1'b0,1'b0,32'h0,       32'hDEAD_BEEF,3'b110,1'b0}, // R4 continuous
      {1'b0,2'd0,2'd0,3'd0,1'b0,1'b0,32'h0,       32'h4444_4444,3'b110,1'b0}, // R10 stays low
      {1'b0,2'd0,2'd0,3'd2,1'b0,1'b0,32'h0,       32'h1234_5678,3'b100,1'b0}, // R4 clear KMAC
      {1'b0,2'd0,2'd0,3'd5,1'b0,1'b0,32'h0,       32'h0F0F_F0F0,3'b000,1'b0}, // R5 clear all
      {1'b1,2'd1,2'd1,3'd0,1'b0,1'b0,32'h7777_0009,32'h5555_5555,3'b001,1'b0}, // R10 reload
      {1'b1,2'd2,2'd1,3'd0,1'b0,1'b0,32'h9999_000A,32'hCAFE_F00D,3'b001,1'b1}, // R9 mismatch
      {1'b0,2'd0,2'd0,3'd0,1'b0,1'b0,32'h0,       32'h6666_6666,3'b001,1'b0}, // R9 pulse ends
      {1'b1,2'd2,2'd2,3'd0,1'b1,1'b0,32'hBBBB_000C,32'h7070_7070,3'b001,1'b0}, // R7 load ignored
      {1'b0,2'd0,2'd0,3'd0,1'b1,1'b0,32'h0,       32'h0101_0101,3'b001,1'b0}, // R7 holds
      {1'b0,2'd0,2'd0,3'd0,1'b0,1'b1,32'h0,       32'hF00D_0001,3'b000,1'b0}, // R8 invalid
      {1'b1,2'd1,2'd1,3'd0,1'b0,1'b0,32'h2468_000F,32'h1357_9BDF,3'b001,1'b0}, // R2 load again
      {1'b1,2'd1,2'd1,3'd1,1'b0,1'b0,32'hEEEE_0010,32'hAAAA_5555,3'b000,1'b0}, // R6 clear wins
      {1'b1,2'd0,2'd1,3'd0,1'b0,1'b0,32'h3333_0011,32'h9191_9191,3'b000,1'b1}  // R9 dest 0
   };

   function automatic string tag(input int i);
      case (i)
         0, 1, 14: return "R2";
         2:        return "R3";
         3, 4, 6:  return "R4";
         7:        return "R5";
         15:       return "R6";
         11, 12:   return "R7";
         13:       return "R8";
         9, 10, 16: return "R9";
         default:  return "R10";
      endcase
   endfunction

   function automatic logic [383:0] fill(input logic [31:0] r);
      logic [383:0] f;
      for (int j = 0; j < 12; j++) f[j*32 +: 32] = (r << j) | (r >> (32 - j));
      return f;
   endfunction

   function automatic logic [383:0] mk_key(input logic [31:0] s);
      logic [383:0] k;
      for (int j = 0; j < 12; j++) k[j*32 +: 32] = s + 32'(j) * 32'h9E37_79B9;
      return k;
   endfunction

   task automatic check(input string req, input string what, input logic [383:0] act,
                        input logic [383:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   logic [383:0] ek [3];

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 reset state
      check("R1", "valids", 384'({aes_vld, kmac_vld, bn_vld, fault}), 384'(0));
      check("R1", "aes key", 384'(aes_key), 384'(0));
      check("R1", "kmac key", 384'(kmac_key), 384'(0));
      check("R1", "bn key", bn_key, 384'(0));
      for (int s = 0; s < 3; s++) ek[s] = '0;

      for (int i = 0; i < NV; i++) begin
         logic [77:0] v;
         v = VEC[i];
         @(negedge clk);
         ld_req = v[77]; ld_dest = v[76:75]; ld_cmd = v[74:73]; clr_sel = v[72:70];
         dis = v[69]; inv = v[68]; ld_key = mk_key(v[67:36]); rnd = v[35:4];
         // expected keys from the requirements
         for (int s = 0; s < 3; s++) begin
            logic [1:0] code;
            code = 2'(s + 1);
            if (inv || clr_sel == 3'(s + 1) || clr_sel > 3'd3) ek[s] = fill(rnd);
            else if (ld_req && ld_dest == code && !dis)
               ek[s] = (ld_cmd == code) ? ld_key : fill(rnd);
         end
         @(posedge clk); #1;
         check(tag(i), $sformatf("vec %0d valids", i), 384'({bn_vld, kmac_vld, aes_vld}), 384'(v[3:1]));
         check(tag(i), $sformatf("vec %0d fault", i), 384'(fault), 384'(v[0]));
         check(tag(i), $sformatf("vec %0d aes key", i), 384'(aes_key), 384'(ek[0][255:0]));
         check(tag(i), $sformatf("vec %0d kmac key", i), 384'(kmac_key), 384'(ek[1][255:0]));
         check(tag(i), $sformatf("vec %0d bn key", i), bn_key, ek[2]);
      end

      // R5: every select value above 3 scrubs all slots; reload first
      for (int sel = 4; sel < 8; sel++) begin
         @(negedge clk);
         ld_req = 1'b1; ld_dest = 2'd3; ld_cmd = 2'd3; clr_sel = '0; inv = 1'b0; dis = 1'b0;
         ld_key = mk_key(32'(sel));
         @(posedge clk); #1;
         check("R3", "bn reload", bn_key, mk_key(32'(sel)));
         @(negedge clk);
         ld_req = 1'b0; clr_sel = 3'(sel); rnd = 32'hABCD_0000 + 32'(sel);
         @(posedge clk); #1;
         check("R5", $sformatf("sel %0d bn valid", sel), 384'(bn_vld), 384'(0));
         check("R5", $sformatf("sel %0d bn fill", sel), bn_key, fill(32'hABCD_0000 + 32'(sel)));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule